// File: doc/BRIEF.md
# Per-Bank Request Queue Dispatcher

This block sits between the request front end of a memory controller and its command engine. Each incoming request names a bank, a row, a direction and a burst length. The block appends the request to a first-in first-out queue that belongs to that bank. It then offers the oldest request of a bank to the command engine whenever that bank is free, and removes the request only when the engine takes it. It never reorders requests, issues no memory commands and checks no timing.

A bank is offered only after something has happened that could let its head request go. Such an event is a new arrival, the start of a read or write burst on that bank, or the end of a refresh. An offer that the engine refuses uses up that chance. The refused request stays at the head and is offered again only after the next such event. When several banks are eligible in the same cycle, a rotating priority picks one of them.

Top module: `bank_req_dispatch`

## Requirements
- R1: Requests for one bank are offered in the order in which they were accepted at the request port.
- R2: `issue_valid_o` is never high for a bank whose `bank_busy_i` bit is high in the same cycle.
- R3: The offered bank, row, direction and burst length are always those of the oldest entry still in that bank's queue.
- R4: An offer is removed from its queue only in a cycle where `issue_accept_i` is high. A refused offer stays at the head of its queue.
- R5: Once a bank's offer has been presented, the bank is not offered again until a new trigger for it arrives. Valid triggers are an arrival for that bank, a burst start on that bank, or a refresh completion.
- R6: A one-cycle pulse on `refresh_done_i` makes every non-empty bank eligible from the next cycle.
- R7: A pulse on `burst_start_i` makes bank `burst_bank_i` eligible from the next cycle.
- R8: A request accepted at the port in cycle n makes its bank eligible in cycle n+1. With the bank idle and no competitor, it is offered in cycle n+1.
- R9: Among eligible banks, the grant goes to the first one found at or after the rotation pointer, in increasing index order with wrap. After every offer the pointer moves to the bank after the one offered.
- R10: `req_ready_o` is low exactly when the queue of `req_bank_i` holds `QUEUE_DEPTH` entries. A request presented while it is low is not stored.
- R11: After reset all queues are empty and no bank is armed. `issue_valid_o` is low and `req_ready_o` is high.
- R12: A trigger that arrives in the same cycle as an offer for that bank takes precedence over the consumption of the chance. The bank stays eligible for the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Target bank queue has room |
| req_bank_i | input | BANK_W | Target bank of the request |
| req_row_i | input | ROW_W | Row of the request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_burst_i | input | BURST_W | Burst length |
| bank_busy_i | input | NUM_BANKS | Per-bank busy from the timing tracker |
| refresh_done_i | input | 1 | Refresh finished; re-arm all banks |
| burst_start_i | input | 1 | Read or write burst began |
| burst_bank_i | input | BANK_W | Bank on which the burst began |
| issue_valid_o | output | 1 | Offer to the command engine |
| issue_accept_i | input | 1 | Engine takes the offer this cycle |
| issue_bank_o | output | BANK_W | Bank of the offer |
| issue_row_o | output | ROW_W | Row of the offer |
| issue_write_o | output | 1 | Direction of the offer |
| issue_burst_o | output | BURST_W | Burst length of the offer |

## Verification
The most delicate overlap is an offer and a trigger for the same bank in the same cycle. An example is a refused offer while `refresh_done_i` or a burst start on that bank is high. Another is an acceptance on a bank while a new request for that same bank is being pushed. The bench provokes the first by holding the refresh completion high for several consecutive cycles while the engine refuses. The bank must then reappear on every following cycle. It provokes the second by pushing back-to-back requests into a bank whose head is being accepted, so that a pop and a push land in the same queue in one cycle. In both cases the reference model applies the consumption first and the new trigger second. Every cycle it compares the offer, its fields and the ready flag against the design.

// File: rtl/bd_pkg.sv
package bd_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } op_e;
endpackage

// File: rtl/bd_bank_fifo.sv
module bd_bank_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign head_o  = mem_q[rd_q];
  assign cnt_o   = cnt_q;

  function automatic logic [PTR_W-1:0] wrap_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wrap_inc(wr_q);
      if (pop_i)  rd_q <= wrap_inc(rd_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/bd_rr_arb.sv
module bd_rr_arb #(
  parameter int N = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  output logic             gnt_valid_o,
  output logic [IDX_W-1:0] gnt_idx_o
);
  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    int idx;
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int i = 0; i < N; i++) begin
      idx = int'(ptr_q) + i;
      if (idx >= N) idx = idx - N;
      if (!gnt_valid_o && req_i[idx]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = IDX_W'(idx);
      end
    end
  end

  // pointer moves past the bank just offered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ptr_q <= '0;
    else if (gnt_valid_o) ptr_q <= (gnt_idx_o == IDX_W'(N - 1)) ? '0 : gnt_idx_o + 1'b1;
  end
endmodule

// File: rtl/bank_req_dispatch.sv
module bank_req_dispatch #(
  parameter int NUM_BANKS   = 4,
  parameter int QUEUE_DEPTH = 4,
  parameter int ROW_W       = 14,
  parameter int BURST_W     = 4,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ENT_W  = ROW_W + BURST_W + 1,
  localparam int CNT_W  = $clog2(QUEUE_DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [BANK_W-1:0]    req_bank_i,
  input  logic [ROW_W-1:0]     req_row_i,
  input  logic                 req_write_i,
  input  logic [BURST_W-1:0]   req_burst_i,
  input  logic [NUM_BANKS-1:0] bank_busy_i,
  input  logic                 refresh_done_i,
  input  logic                 burst_start_i,
  input  logic [BANK_W-1:0]    burst_bank_i,
  output logic                 issue_valid_o,
  input  logic                 issue_accept_i,
  output logic [BANK_W-1:0]    issue_bank_o,
  output logic [ROW_W-1:0]     issue_row_o,
  output logic                 issue_write_o,
  output logic [BURST_W-1:0]   issue_burst_o
);
  import bd_pkg::*;

  logic [NUM_BANKS-1:0]            push_v, pop_v, empty_v, full_v;
  logic [NUM_BANKS-1:0]            arm_set, arm_clr, armed_q, elig;
  logic [NUM_BANKS-1:0][ENT_W-1:0] head_v;
  logic [NUM_BANKS-1:0][CNT_W-1:0] bank_cnt;
  logic [ENT_W-1:0]                wr_ent, sel_ent;
  logic                            gnt_valid;
  logic [BANK_W-1:0]               gnt_idx;
  op_e                             sel_op;

  assign req_ready_o = !full_v[req_bank_i];
  assign wr_ent      = {req_write_i, req_burst_i, req_row_i};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign push_v[b]  = req_valid_i && req_ready_o && (req_bank_i == BANK_W'(b));
    assign pop_v[b]   = gnt_valid && issue_accept_i && (gnt_idx == BANK_W'(b));
    assign arm_clr[b] = gnt_valid && (gnt_idx == BANK_W'(b));
    assign arm_set[b] = push_v[b] || refresh_done_i
                     || (burst_start_i && (burst_bank_i == BANK_W'(b)));

    bd_bank_fifo #(.DEPTH(QUEUE_DEPTH), .W(ENT_W)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push_v[b]),
      .data_i  (wr_ent),
      .pop_i   (pop_v[b]),
      .head_o  (head_v[b]),
      .empty_o (empty_v[b]),
      .full_o  (full_v[b]),
      .cnt_o   (bank_cnt[b])
    );
  end

  // a new trigger outranks the chance consumed by this cycle's offer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= '0;
    else         armed_q <= (armed_q & ~arm_clr) | arm_set;
  end

  assign elig = armed_q & ~empty_v & ~bank_busy_i;

  bd_rr_arb #(.N(NUM_BANKS)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (elig),
    .gnt_valid_o (gnt_valid),
    .gnt_idx_o   (gnt_idx)
  );

  assign sel_ent       = head_v[gnt_idx];
  assign sel_op        = op_e'(sel_ent[ENT_W-1]);
  assign issue_valid_o = gnt_valid;
  assign issue_bank_o  = gnt_idx;
  assign issue_row_o   = sel_ent[ROW_W-1:0];
  assign issue_burst_o = sel_ent[ROW_W +: BURST_W];
  assign issue_write_o = (sel_op == OP_WRITE);
endmodule

// File: rtl/bd_checker.sv
module bd_checker #(
  parameter int NUM_BANKS   = 4,
  parameter int QUEUE_DEPTH = 4,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int CNT_W  = $clog2(QUEUE_DEPTH + 1)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            req_valid_i,
  input logic                            req_ready_o,
  input logic [BANK_W-1:0]               req_bank_i,
  input logic [NUM_BANKS-1:0]            bank_busy_i,
  input logic                            refresh_done_i,
  input logic                            burst_start_i,
  input logic [BANK_W-1:0]               burst_bank_i,
  input logic                            issue_valid_o,
  input logic                            issue_accept_i,
  input logic [BANK_W-1:0]               issue_bank_o,
  input logic [NUM_BANKS-1:0][CNT_W-1:0] bank_cnt
);
  logic push_same, pushed;
  assign pushed    = req_valid_i && req_ready_o;
  assign push_same = pushed && (req_bank_i == issue_bank_o);

  a_r2_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> !bank_busy_i[issue_bank_o]);

  a_r3_offer_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> (bank_cnt[issue_bank_o] != '0));

  a_r4_accept_pops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && issue_accept_i && !push_same)
    |=> (bank_cnt[$past(issue_bank_o)] == $past(bank_cnt[issue_bank_o]) - 1'b1));

  a_r4_refuse_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && !issue_accept_i && !push_same)
    |=> (bank_cnt[$past(issue_bank_o)] == $past(bank_cnt[issue_bank_o])));

  a_r5_no_retry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && !refresh_done_i && !push_same
     && !(burst_start_i && burst_bank_i == issue_bank_o))
    |=> !(issue_valid_o && issue_bank_o == $past(issue_bank_o)));

  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pushed && !(issue_valid_o && issue_accept_i && issue_bank_o == req_bank_i))
    |=> (bank_cnt[$past(req_bank_i)] == $past(bank_cnt[req_bank_i]) + 1'b1)
        && (bank_cnt[$past(req_bank_i)] <= CNT_W'(QUEUE_DEPTH)));
endmodule

bind bank_req_dispatch bd_checker #(
  .NUM_BANKS   (NUM_BANKS),
  .QUEUE_DEPTH (QUEUE_DEPTH)
) u_bd_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .req_bank_i     (req_bank_i),
  .bank_busy_i    (bank_busy_i),
  .refresh_done_i (refresh_done_i),
  .burst_start_i  (burst_start_i),
  .burst_bank_i   (burst_bank_i),
  .issue_valid_o  (issue_valid_o),
  .issue_accept_i (issue_accept_i),
  .issue_bank_o   (issue_bank_o),
  .bank_cnt       (bank_cnt)
);

// File: tb/tb_bank_req_dispatch.sv
module tb_bank_req_dispatch;
  localparam int NB = 4;
  localparam int DEPTH = 4;
  localparam int ROW_W = 14;
  localparam int BURST_W = 4;
  localparam int BANK_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic               req_valid = 0, req_write = 0;
  logic [BANK_W-1:0]  req_bank = 0, burst_bank = 0;
  logic [ROW_W-1:0]   req_row = 0;
  logic [BURST_W-1:0] req_burst = 0;
  logic [NB-1:0]      busy = 0;
  logic               refresh = 0, burst_start = 0, accept = 0;
  logic               req_ready, iv, iw;
  logic [BANK_W-1:0]  ib;
  logic [ROW_W-1:0]   ir;
  logic [BURST_W-1:0] ibl;

  bank_req_dispatch #(.NUM_BANKS(NB), .QUEUE_DEPTH(DEPTH), .ROW_W(ROW_W), .BURST_W(BURST_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_bank_i(req_bank),
    .req_row_i(req_row), .req_write_i(req_write), .req_burst_i(req_burst),
    .bank_busy_i(busy), .refresh_done_i(refresh),
    .burst_start_i(burst_start), .burst_bank_i(burst_bank),
    .issue_valid_o(iv), .issue_accept_i(accept), .issue_bank_o(ib),
    .issue_row_o(ir), .issue_write_o(iw), .issue_burst_o(ibl)
  );

  int n_cmp = 0, n_bad = 0, n_cyc = 0;
  bit done = 0;
  string tag = "R11";

  // reference model state
  int qrow[NB][$];
  int qbl[NB][$];
  bit qwr[NB][$];
  bit armed[NB];
  int rr_ptr;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: cycles %0d expected below 100000", n_cyc);
      done = 1;
      summary();
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        qrow[b].delete(); qbl[b].delete(); qwr[b].delete(); armed[b] = 0;
      end
      rr_ptr = 0;
    end else if (!done) begin
      bit ev, er, ew;
      int eb, erow, ebl, idx;
      ev = 0; eb = 0; erow = 0; ebl = 0; ew = 0;
      for (int i = 0; i < NB; i++) begin
        idx = (rr_ptr + i) % NB;
        if (!ev && armed[idx] && qrow[idx].size() > 0 && !busy[idx]) begin
          ev = 1; eb = idx;
        end
      end
      if (ev) begin erow = qrow[eb][0]; ebl = qbl[eb][0]; ew = qwr[eb][0]; end
      er = (qrow[req_bank].size() < DEPTH);
      n_cmp++;
      if (iv !== ev || req_ready !== er ||
          (ev && (int'(ib) != eb || int'(ir) != erow || int'(ibl) != ebl || iw !== ew))) begin
        n_bad++;
        $display("FAIL %s cyc %0d: act v=%0d b=%0d row=%0d bl=%0d w=%0d rdy=%0d exp v=%0d b=%0d row=%0d bl=%0d w=%0d rdy=%0d",
                 tag, n_cyc, iv, ib, ir, ibl, iw, req_ready, ev, eb, erow, ebl, ew, er);
      end
      // next-state: consume chance, then apply triggers
      if (ev) begin
        rr_ptr = (eb + 1) % NB;
        armed[eb] = 0;
        if (accept) begin
          void'(qrow[eb].pop_front()); void'(qbl[eb].pop_front()); void'(qwr[eb].pop_front());
        end
      end
      if (req_valid && er) begin
        qrow[req_bank].push_back(int'(req_row));
        qbl[req_bank].push_back(int'(req_burst));
        qwr[req_bank].push_back(req_write);
        armed[req_bank] = 1;
      end
      if (burst_start) armed[burst_bank] = 1;
      if (refresh) for (int b = 0; b < NB; b++) armed[b] = 1;
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic push(int b, int row);
    req_valid = 1; req_bank = BANK_W'(b); req_row = ROW_W'(row);
    req_write = row[0]; req_burst = BURST_W'(row % 9);
    cyc(1);
    req_valid = 0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    tag = "R11"; cyc(2);                          // reset state: idle, ready
    tag = "R8";  accept = 1; push(0, 10); cyc(2); // arrival offered next cycle
    tag = "R1";  push(0, 11); push(0, 12); cyc(2);
    busy[0] = 1; push(0, 13); push(0, 14); cyc(2);
    busy[0] = 0; cyc(3);
    tag = "R7";  burst_start = 1; burst_bank = 0; cyc(1); burst_start = 0; cyc(2);
    tag = "R2";  busy[1] = 1; push(1, 20); cyc(4); busy[1] = 0; cyc(2);
    tag = "R4";  accept = 0; push(2, 30); cyc(3);
    tag = "R5";  cyc(3);
    tag = "R6";  refresh = 1; cyc(1); refresh = 0; cyc(2);
    tag = "R12"; refresh = 1; cyc(3); refresh = 0; cyc(2);
    accept = 1; refresh = 1; cyc(1); refresh = 0; cyc(2);
    tag = "R9";  accept = 0; push(3, 40); push(1, 41); push(0, 42); push(2, 43);
    refresh = 1; cyc(8); refresh = 0; accept = 1; refresh = 1; cyc(5); refresh = 0; cyc(2);
    tag = "R10"; accept = 0; busy[3] = 1;
    for (int k = 0; k < 6; k++) push(3, 50 + k);
    cyc(2); busy[3] = 0; accept = 1; refresh = 1; cyc(6); refresh = 0; cyc(2);
    tag = "R3";
    for (int k = 0; k < 1500; k++) begin
      req_valid   = ($urandom_range(0, 2) != 0);
      req_bank    = BANK_W'($urandom_range(0, NB - 1));
      req_row     = ROW_W'($urandom);
      req_write   = 1'($urandom);
      req_burst   = BURST_W'($urandom);
      busy        = NB'($urandom) & NB'($urandom);
      refresh     = ($urandom_range(0, 9) == 0);
      burst_start = ($urandom_range(0, 2) == 0);
      burst_bank  = BANK_W'($urandom_range(0, NB - 1));
      accept      = ($urandom_range(0, 3) != 0);
      cyc(1);
    end
    req_valid = 0; busy = 0; burst_start = 0; accept = 1; refresh = 1; cyc(20);
    refresh = 0; cyc(2);
    done = 1;
    summary();
  end
endmodule